// File: doc/BRIEF.md
# Spread-Spectrum Fractional Divider Modulator

This block drives the feedback divider word of a fractional-N frequency synthesizer. It adds a triangular offset to a base word so that the synthesized frequency sweeps slowly around its nominal value. Spreading the frequency this way lowers the peak of radiated emissions. The base word has an 8-bit integer part and an 18-bit fraction, so the effective ratio is integer + fraction/2^18. On every reference clock the block outputs a 26-bit word.

Three 16-bit values set the shape of the triangle. The segment length `seg_len` sets how long each ramp lasts. The `step_size` value is the amount the offset moves per update. The `upd_period` value sets how many cycles pass between updates. One bit turns spreading on. A second bit chooses between a down-only spread and a spread centred on the base word. Software normally sets the segment length to the reference frequency divided by the spread frequency, rounded, halved and minus one. With a 19.2 MHz reference and a 31.5 kHz spread that gives 304. The step size is sized from the base word, the spread depth and the update interval.

Top module: `ssc_divword_mod`

## Requirements
- R1: `div_word` equals {`base_int`,`base_frac`} plus the signed offset, taken modulo 2^26. The integer part sits in bits [25:18] and the fraction in bits [17:0].
- R2: While `spread_en` is 0, `div_word` equals {`base_int`,`base_frac`} in the same cycle, and it follows changes of the base inputs at once.
- R3: The offset changes by exactly one step size on every (U+1)-th enabled cycle of a segment, where U is the update period. The update count restarts at each segment start. On all other cycles the offset holds.
- R4: A segment lasts H+1 enabled cycles, where H is the segment length. In down mode (`center_sel`=0) segment 0 ramps down and segment 1 ramps up. The minimum offset is -floor((H+1)/(U+1))*S.
- R5: In center mode (`center_sel`=1) the four segments go up, down, down and up. The offset swings between +N*S and -N*S, with N = floor((H+1)/(U+1)).
- R6: H, S, U and the mode are held in shadow copies. These copies load only while spreading is disabled or when a full period ends, which is always at zero offset. A change in mid-period has no effect until that point.
- R7: A cycle with `spread_en` at 0 clears the offset and the segment and update counters. The next enabled stretch starts at zero offset in segment 0.
- R8: After reset the offset and all counters are zero, so `div_word` equals the base word.
- R9: A down spread below a base word of zero wraps. The first step from base 0 with step S gives 2^26 - S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spread_en | input | 1 | Enable spreading |
| center_sel | input | 1 | 1 = center spread, 0 = down spread |
| base_int | input | 8 | Integer part of base divider word |
| base_frac | input | 18 | Fractional part of base divider word |
| seg_len | input | 16 | Segment length H (segment = H+1 cycles) |
| step_size | input | 16 | Offset step S |
| upd_period | input | 16 | Update period U (update every U+1 cycles) |
| div_word | output | 26 | Modulated divider word |

## Verification
Wrong internal state shows up on `div_word` very quickly. A bad update counter moves the word on the wrong cycle, so the error is visible within U+1 cycles of enabling. A bad segment counter or direction gives a wrong peak or a wrong turning point within one segment. A shadow copy that loads too early changes the slope in the middle of a period. An offset that is not cleared leaves a non-zero residue at the first sample after enabling. The bench compares the output with a behavioural model on every cycle, so each of these faults is caught in the cycle where it first appears.

// File: rtl/ssc_divword_mod.sv
module ssc_divword_mod #(
  parameter int IW = 8,
  parameter int FW = 18,
  parameter int PW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spread_en,
  input  logic             center_sel,
  input  logic [IW-1:0]    base_int,
  input  logic [FW-1:0]    base_frac,
  input  logic [PW-1:0]    seg_len,
  input  logic [PW-1:0]    step_size,
  input  logic [PW-1:0]    upd_period,
  output logic [IW+FW-1:0] div_word
);
  localparam int WW = IW + FW;
  localparam int OW = WW + 1;

  logic signed [OW-1:0] ofs;
  logic [PW-1:0] hcnt, acnt, sh_half, sh_step, sh_adj;
  logic [1:0] seg;
  logic sh_center;

  logic [WW-1:0] base;
  logic step_now, seg_end, seg_last, go_up;
  logic signed [OW-1:0] stp;

  assign base     = {base_int, base_frac};
  assign step_now = acnt == sh_adj;
  assign seg_end  = hcnt == sh_half;
  assign seg_last = sh_center ? (seg == 2'd3) : (seg == 2'd1);
  assign go_up    = sh_center ? (seg == 2'd0 || seg == 2'd3) : (seg == 2'd1);
  assign stp      = OW'(sh_step);
  assign div_word = spread_en ? base + ofs[WW-1:0] : base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs <= '0; hcnt <= '0; acnt <= '0; seg <= '0;
      sh_half <= '0; sh_step <= '0; sh_adj <= '0; sh_center <= 1'b0;
    end else if (!spread_en) begin
      ofs <= '0; hcnt <= '0; acnt <= '0; seg <= '0;
      sh_half <= seg_len; sh_step <= step_size;
      sh_adj <= upd_period; sh_center <= center_sel;
    end else begin
      if (step_now)
        ofs <= go_up ? ofs + stp : ofs - stp;
      acnt <= (step_now || seg_end) ? '0 : acnt + 1'b1;
      hcnt <= seg_end ? '0 : hcnt + 1'b1;
      if (seg_end) begin
        if (seg_last) begin
          seg <= '0;
          sh_half <= seg_len; sh_step <= step_size;
          sh_adj <= upd_period; sh_center <= center_sel;
        end else begin
          seg <= seg + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/ssc_divword_chk.sv
module ssc_divword_chk #(
  parameter int WW = 26,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spread_en,
  input logic [WW-1:0] base,
  input logic [WW-1:0] div_word,
  input logic [WW:0]   ofs,
  input logic [PW-1:0] hcnt,
  input logic [PW-1:0] acnt,
  input logic [PW-1:0] sh_half,
  input logic [1:0]    seg,
  input logic          sh_center
);
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !spread_en |-> div_word == base);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !spread_en |=> (ofs == '0 && seg == 2'd0 && hcnt == '0));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spread_en && acnt != '0) |-> ofs == $past(ofs));
  p_seg_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spread_en |-> hcnt <= sh_half);
  p_down_segs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_center |-> seg < 2'd2);
  p_period_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spread_en && $past(spread_en) && seg == 2'd0 && hcnt == '0) |-> ofs == '0);
endmodule

bind ssc_divword_mod ssc_divword_chk #(.WW(IW+FW), .PW(PW)) chk (
  .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .base(base),
  .div_word(div_word), .ofs(ofs), .hcnt(hcnt), .acnt(acnt),
  .sh_half(sh_half), .seg(seg), .sh_center(sh_center)
);

// File: tb/ssc_divword_mod_test.sv
`timescale 1ns/1ps
module ssc_divword_mod_test;
  logic clk = 0, rst_n = 0, en = 0, ctr = 0;
  logic [7:0] bi = 8'd100;
  logic [17:0] bf = 18'd0;
  logic [15:0] hl = 0, st = 0, ad = 0;
  logic [25:0] dw;
  int total = 0, bad = 0;
  string tag = "R8";
  bit finished = 0;

  always #2 clk = ~clk;

  ssc_divword_mod uut (.clk(clk), .rst_n(rst_n), .spread_en(en), .center_sel(ctr),
    .base_int(bi), .base_frac(bf), .seg_len(hl), .step_size(st),
    .upd_period(ad), .div_word(dw));

  longint m_ofs;
  int hc, ac, sg, shH, shS, shA;
  bit shC;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ofs = 0; hc = 0; ac = 0; sg = 0; shH = 0; shS = 0; shA = 0; shC = 0;
    end else if (!en) begin
      m_ofs = 0; hc = 0; ac = 0; sg = 0;
      shH = hl; shS = st; shA = ad; shC = ctr;
    end else begin
      bit sn, se, up, last;
      sn = (ac == shA); se = (hc == shH);
      up = shC ? (sg == 0 || sg == 3) : (sg == 1);
      if (sn) m_ofs = up ? m_ofs + shS : m_ofs - shS;
      ac = (sn || se) ? 0 : ac + 1;
      hc = se ? 0 : hc + 1;
      if (se) begin
        last = shC ? (sg == 3) : (sg == 1);
        if (last) begin
          sg = 0; shH = hl; shS = st; shA = ad; shC = ctr;
        end else sg = sg + 1;
      end
    end
  end

  function automatic longint basev();
    return (longint'(bi) << 18) + bf;
  endfunction

  function automatic longint expv();
    return en ? ((basev() + m_ofs) & 64'h3FFFFFF) : basev();
  endfunction

  task automatic check(string t, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  longint mn, mx;
  always @(negedge clk) if (rst_n) begin
    longint d;
    check(tag, dw, expv());
    d = longint'(dw) - basev();
    if (en) begin
      if (d < mn) mn = d;
      if (d > mx) mx = d;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    step(3); rst_n = 1; step(1);
    check("R8 reset", dw, basev());
    tag = "R2"; bf = 18'd777; #0.5; check("R2 passthru", dw, basev());
    step(3);
    // down spread: H=7, U=1, S=100 -> N=4, min -400
    tag = "R4"; hl = 7; ad = 1; st = 100; ctr = 0; step(1);
    mn = 0; mx = 0; en = 1;
    step(2); check("R3 first step after U+1 cycles", longint'(dw) - basev(), -100);
    step(14);
    check("R4 min of down spread", mn, -400);
    check("R4 never above base", mx, 0);
    check("R4 back to zero at period end", longint'(dw) - basev(), 0);
    // R6: change step mid-period
    tag = "R6"; step(5); st = 50; hl = 3; step(11);
    check("R6 old step kept within period", mn, -400);
    step(16);
    // R5 center: H=5, U=0, S=3 -> +/-18
    tag = "R7"; en = 0; ctr = 1; hl = 5; ad = 0; st = 3; step(1);
    check("R7 disabled output", dw, basev());
    tag = "R5"; mn = 0; mx = 0; en = 1;
    step(1); check("R7 restart from zero then first step", longint'(dw) - basev(), 3);
    step(23);
    check("R5 center max", mx, 18);
    check("R5 center min", mn, -18);
    check("R5 period end zero", longint'(dw) - basev(), 0);
    step(30);
    // R9 wrap at base 0
    tag = "R9"; en = 0; ctr = 0; bi = 0; bf = 0; hl = 9; ad = 0; st = 5; step(1);
    en = 1; step(1);
    check("R9 wrap below zero", dw, 64'h4000000 - 5);
    tag = "R1"; bi = 8'h3C; bf = 18'h2A5A5; step(1);
    check("R1 word layout", dw[25:18], (8'h3C + ((longint'(18'h2A5A5) + (64'h4000000 - 10)) >> 18)) & 8'hFF);
    step(40);
    tag = "R7"; en = 0; step(1); en = 1; step(1);
    check("R7 re-enable starts at zero", longint'(dw) - basev(), -5);
    step(20);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule